// File: doc/BRIEF.md
# Feature Status Query Mailbox

This block is the device-side responder of a small register mailbox. A host claims the mailbox by writing a command word that names an 8-bit feature and a command code, launches the command by setting a run/busy bit together with a packet length, polls until the block drops run/busy, checks a coded result, reads the 32-bit status word of the feature, and finally writes a completion bit that hands the mailbox back.

Ownership is tracked as a two-bit field: free, held by the in-band host, or held by an out-of-band agent. The out-of-band agent is modelled as a single input that claims the mailbox whenever it is otherwise free. Feature status comes from an internal table, loaded through a dedicated write port and indexed directly by the low bits of the feature number. The lookup takes a fixed, configurable number of cycles, so the host always observes run/busy set before it clears.

All register reads return one cycle after the read strobe. The response word is also driven on a dedicated output.

Top module: `fqmb_top`

## Requirements
- R1: After a synchronous reset the owner is free (0), run/busy, result, length, the response word and the read data are all zero.
- R2: Reads at byte offset 0x0 return the status register (run/busy bit 0, owner [5:4], bit 6 reads 0, result [15:8], length [31:16]); 0x8 returns the command register; 0xC returns the response word in bits [31:0]. Read data appears in the cycle after the read strobe and is zero in any cycle without a read or for any other offset.
- R3: A write to offset 0x8 while the visible owner is free stores the command code from bits [7:0] and the 9-bit feature number from bits [48:40], and makes the owner in-band (1); reading 0x8 returns those two fields in the same positions with all other bits zero.
- R4: A write to offset 0x8 while the visible owner is not free leaves the command register unchanged.
- R5: While the out-of-band hold input is high and the stored owner is free, the owner reads as 2 and a command write is ignored; the hold input does not disturb an in-band owner.
- R6: A status write with bit 0 set, bit 6 clear and length bits [31:16] equal to 2, while the owner is in-band and run/busy is clear, sets run/busy and records length 2; any other status write without bit 6 leaves run/busy and length unchanged.
- R7: Once launched, run/busy stays set for exactly LOOKUP_CYC register cycles and then clears by itself.
- R8: Command code 0x10 on a feature whose table entry is valid finishes with result 0x40 and response word: enabled bit 0, write-blocked bit 4, read-blocked bit 5, out-of-band-select bit 6, feature number [15:8], locked bit 31, other bits zero.
- R9: Any other command code, a feature number at or above the table depth, or an entry with its valid flag clear finishes with result 0x01 and a response word of zero.
- R10: A status write with bit 6 set returns the owner to free and clears run/busy (aborting a lookup in progress), result and length; the response word keeps its value.
- R11: Table write port data is {locked, out-of-band select, read-blocked, write-blocked, enabled, valid} from bit 5 down to bit 0; writes to offset 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Register read data, one cycle after the read strobe |
| oob_hold | input | 1 | Out-of-band agent claims the mailbox when free |
| tbl_we | input | 1 | Feature table write enable |
| tbl_addr | input | IDX_W | Feature table entry index |
| tbl_wdata | input | 6 | Feature table entry flags |
| resp_word | output | 32 | Current response word |

## Verification
Complete transactions are run for two valid features with different flag mixes so that every response bit position is separated, then for an unknown command code, an invalid entry and a feature number with bit 8 set, which must all be told apart from success by result code and a zero response. Protocol misuse is applied between these: a second command write while owned, launches with the wrong length or without ownership, an out-of-band hold against both a free and an owned mailbox, and a completion write in the middle of a lookup. Status is polled every cycle during each lookup so that the exact length of the busy window is compared against the reference model.

// File: rtl/fqmb_pkg.sv
package fqmb_pkg;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 4;
  localparam int RESP_W = 32;
  localparam int FID_W  = 9;

  typedef enum logic [1:0] {
    OWN_NONE   = 2'd0,
    OWN_INBAND = 2'd1,
    OWN_OOB    = 2'd2
  } owner_e;

  typedef struct packed {
    logic locked;
    logic oob_sel;
    logic rd_blk;
    logic wr_blk;
    logic enabled;
    logic valid;
  } feat_ent_t;

  localparam int ENT_W = $bits(feat_ent_t);

  localparam logic [7:0]  RES_OK        = 8'h40;
  localparam logic [7:0]  RES_ERR       = 8'h01;
  localparam logic [7:0]  CMD_GET_STATE = 8'h10;
  localparam logic [15:0] LAUNCH_LEN    = 16'd2;

  localparam logic [ADDR_W-1:0] OFF_STAT = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_RESP = 4'hC;

  localparam int BIT_RB  = 0;
  localparam int BIT_CPL = 6;

endpackage

// File: rtl/fqmb_table.sv
module fqmb_table
  import fqmb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  feat_ent_t        wdata,
  input  logic [IDX_W-1:0] raddr,
  output feat_ent_t        rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;

  // Single write port, single registered read port: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rd_q <= mem[raddr];
  end

  assign rdata = feat_ent_t'(rd_q);

endmodule

// File: rtl/fqmb_ctrl.sv
module fqmb_ctrl
  import fqmb_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int LOOKUP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oob_hold,
  input  feat_ent_t         ent,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [1:0]        owner_vis,
  output logic              rb,
  output logic [7:0]        result,
  output logic [15:0]       len,
  output logic [7:0]        cmd_code,
  output logic [FID_W-1:0]  cmd_fid,
  output logic [RESP_W-1:0] resp
);

  localparam int CNT_W = (LOOKUP_CYC > 2) ? $clog2(LOOKUP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LOOKUP_CYC - 1);

  owner_e             owner_q;
  logic               rb_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [7:0]         result_q;
  logic [15:0]        len_q;
  logic [7:0]         code_q;
  logic [FID_W-1:0]   fid_q;
  logic [RESP_W-1:0]  resp_q;

  logic               stat_wr;
  logic               cmd_wr;
  logic               cpl_req;
  logic               launch;
  logic               cmd_ok;
  logic               hit;
  logic               done;
  logic [1:0]         vis;
  logic [RESP_W-1:0]  resp_hit;
  logic               unused_wbits;

  assign unused_wbits = ^{wdata[63:49], wdata[39:32], wdata[15:8]};

  assign vis = (owner_q == OWN_NONE && oob_hold) ? OWN_OOB : owner_q;

  assign stat_wr = wr_en && (addr == OFF_STAT);
  assign cmd_wr  = wr_en && (addr == OFF_CMD);
  assign cpl_req = stat_wr && wdata[BIT_CPL];
  assign launch  = stat_wr && !wdata[BIT_CPL] && wdata[BIT_RB] &&
                   (wdata[31:16] == LAUNCH_LEN) &&
                   (owner_q == OWN_INBAND) && !rb_q;
  assign cmd_ok  = cmd_wr && (vis == OWN_NONE);
  assign done    = rb_q && (cnt_q == '0) && !cpl_req;

  assign hit = (code_q == CMD_GET_STATE) && ((fid_q >> IDX_W) == '0) && ent.valid;

  assign resp_hit = {ent.locked, 15'h0, fid_q[7:0], 1'b0,
                     ent.oob_sel, ent.rd_blk, ent.wr_blk, 3'b000, ent.enabled};

  // Owner and command register
  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_NONE;
      code_q  <= '0;
      fid_q   <= '0;
    end else if (cmd_ok) begin
      owner_q <= OWN_INBAND;
      code_q  <= wdata[7:0];
      fid_q   <= wdata[48:40];
    end else if (cpl_req) begin
      owner_q <= OWN_NONE;
    end
  end

  // Run/busy, lookup countdown, result and response
  always_ff @(posedge clk) begin
    if (rst) begin
      rb_q     <= 1'b0;
      cnt_q    <= '0;
      result_q <= '0;
      len_q    <= '0;
      resp_q   <= '0;
    end else if (cpl_req) begin
      rb_q     <= 1'b0;
      cnt_q    <= '0;
      result_q <= '0;
      len_q    <= '0;
    end else if (launch) begin
      rb_q     <= 1'b1;
      cnt_q    <= CNT_INIT;
      len_q    <= LAUNCH_LEN;
    end else if (rb_q) begin
      if (cnt_q == '0) begin
        rb_q     <= 1'b0;
        result_q <= hit ? RES_OK : RES_ERR;
        resp_q   <= hit ? resp_hit : '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign lk_idx    = fid_q[IDX_W-1:0];
  assign owner_vis = vis;
  assign rb        = rb_q;
  assign result    = result_q;
  assign len       = len_q;
  assign cmd_code  = code_q;
  assign cmd_fid   = fid_q;
  assign resp      = resp_q;

  initial begin
    assert_lat_min_R7: assert (LOOKUP_CYC >= 2);
  end

  assert_busy_owned_R6: assert property (@(posedge clk) disable iff (rst)
    rb_q |-> (owner_q == OWN_INBAND));

  assert_cmd_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && vis != OWN_NONE) |=> ($stable(code_q) && $stable(fid_q)));

  assert_oob_block_R5: assert property (@(posedge clk) disable iff (rst)
    (oob_hold && owner_q == OWN_NONE && cmd_wr) |=> (owner_q == OWN_NONE));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rb_q && cnt_q != '0 && !cpl_req) |=> rb_q);

  assert_result_code_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (!rb_q && (result_q == RES_OK || result_q == RES_ERR)));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (result_q == RES_ERR) |-> (resp_q == '0));

  assert_cpl_release_R10: assert property (@(posedge clk) disable iff (rst)
    cpl_req |=> (owner_q == OWN_NONE && !rb_q && result_q == '0 && $stable(resp_q)));

endmodule

// File: rtl/fqmb_rdmux.sv
module fqmb_rdmux
  import fqmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        owner_vis,
  input  logic              rb,
  input  logic [7:0]        result,
  input  logic [15:0]       len,
  input  logic [7:0]        cmd_code,
  input  logic [FID_W-1:0]  cmd_fid,
  input  logic [RESP_W-1:0] resp,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] cmd_word;
  logic [DATA_W-1:0] resp_word64;
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rdata_q;

  assign stat_word   = {32'h0, len, result, 2'b00, owner_vis, 3'b000, rb};
  assign cmd_word    = {15'h0, cmd_fid, 32'h0, cmd_code};
  assign resp_word64 = {32'h0, resp};

  always_comb begin
    sel = '0;
    if (rd_en) begin
      case (addr)
        OFF_STAT: sel = stat_word;
        OFF_CMD:  sel = cmd_word;
        OFF_RESP: sel = resp_word64;
        default:  sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= sel;
    end
  end

  assign rdata = rdata_q;

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata_q == '0));

  assert_bad_offset_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != OFF_STAT && addr != OFF_CMD && addr != OFF_RESP) |=> (rdata_q == '0));

endmodule

// File: rtl/fqmb_top.sv
module fqmb_top
  import fqmb_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int LOOKUP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [3:0]        bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic              oob_hold,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [5:0]        tbl_wdata,
  output logic [31:0]       resp_word
);

  feat_ent_t          ent;
  logic [IDX_W-1:0]   lk_idx;
  logic [1:0]         owner_vis;
  logic               rb;
  logic [7:0]         result;
  logic [15:0]        len;
  logic [7:0]         cmd_code;
  logic [FID_W-1:0]   cmd_fid;
  logic [RESP_W-1:0]  resp;

  fqmb_table #(.IDX_W(IDX_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (feat_ent_t'(tbl_wdata)),
    .raddr (lk_idx),
    .rdata (ent)
  );

  fqmb_ctrl #(.IDX_W(IDX_W), .LOOKUP_CYC(LOOKUP_CYC)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr_en),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .oob_hold  (oob_hold),
    .ent       (ent),
    .lk_idx    (lk_idx),
    .owner_vis (owner_vis),
    .rb        (rb),
    .result    (result),
    .len       (len),
    .cmd_code  (cmd_code),
    .cmd_fid   (cmd_fid),
    .resp      (resp)
  );

  fqmb_rdmux u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (bus_rd_en),
    .addr      (bus_addr),
    .owner_vis (owner_vis),
    .rb        (rb),
    .result    (result),
    .len       (len),
    .cmd_code  (cmd_code),
    .cmd_fid   (cmd_fid),
    .resp      (resp),
    .rdata     (bus_rdata)
  );

  assign resp_word = resp;

endmodule

// File: tb/fqmb_top_bench.sv
module fqmb_top_bench;

  localparam int IDX_W = 4;
  localparam int DEPTH = 16;
  localparam int LAT   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wd = '0;
  logic [63:0] rdata;
  logic        oob = 1'b0;
  logic        twe = 1'b0;
  logic [3:0]  taddr = '0;
  logic [5:0]  tdata = '0;
  logic [31:0] resp;

  always #4 clk = ~clk;

  fqmb_top #(.IDX_W(IDX_W), .LOOKUP_CYC(LAT)) u_fqmb_top (
    .clk(clk), .rst(rst), .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rdata), .oob_hold(oob), .tbl_we(twe),
    .tbl_addr(taddr), .tbl_wdata(tdata), .resp_word(resp)
  );

  // Behavioural reference model
  int          m_own, m_cnt;
  bit          m_rb;
  logic [7:0]  m_res, m_code;
  logic [15:0] m_len;
  logic [8:0]  m_fid;
  logic [31:0] m_resp;
  logic [63:0] m_rdata;
  logic [5:0]  m_tbl [DEPTH];
  bit          started = 0;
  int          vectors = 0, fails = 0, cyc = 0;
  string       cur_req = "R1";

  always @(posedge clk) begin : mdl
    logic [1:0]  vis;
    logic [63:0] nd;
    logic [5:0]  e;
    bit          hit;
    started = 1;
    if (rst) begin
      m_own = 0; m_rb = 0; m_cnt = 0; m_res = 0; m_len = 0;
      m_code = 0; m_fid = 0; m_resp = 0; m_rdata = 0;
    end else begin
      vis = (m_own == 0 && oob) ? 2'd2 : 2'(m_own);
      nd = 0;
      if (rd) begin
        if (addr == 4'h0)      nd = {32'h0, m_len, m_res, 2'b00, vis, 3'b000, m_rb};
        else if (addr == 4'h8) nd = {15'h0, m_fid, 32'h0, m_code};
        else if (addr == 4'hC) nd = {32'h0, m_resp};
      end
      e = m_tbl[m_fid[3:0]];
      hit = (m_code == 8'h10) && (m_fid < DEPTH) && e[0];
      if (wr && addr == 4'h0 && wd[6]) begin
        m_own = 0; m_rb = 0; m_cnt = 0; m_res = 0; m_len = 0;
      end else if (wr && addr == 4'h0 && wd[0] && wd[31:16] == 16'd2 && m_own == 1 && !m_rb) begin
        m_rb = 1; m_cnt = LAT - 1; m_len = 16'd2;
      end else if (m_rb) begin
        if (m_cnt == 0) begin
          m_rb = 0;
          m_res = hit ? 8'h40 : 8'h01;
          m_resp = hit ? {e[5], 15'h0, m_fid[7:0], 1'b0, e[4], e[3], e[2], 3'b000, e[1]} : 32'h0;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
      if (wr && addr == 4'h8 && vis == 2'd0) begin
        m_code = wd[7:0]; m_fid = wd[48:40]; m_own = 1;
      end
      m_rdata = nd;
    end
    if (twe) m_tbl[taddr] = tdata;
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      vectors++;
      if (rdata !== m_rdata || resp !== m_resp) begin
        fails++;
        $display("FAIL %s: rdata=%h exp=%h resp=%h exp=%h", cur_req, rdata, m_rdata, resp, m_resp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d exp<=50000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic do_wr(input logic [3:0] a, input logic [63:0] d);
    wr = 1; addr = a; wd = d;
    @(negedge clk);
    wr = 0; wd = '0;
  endtask

  task automatic do_rd(input logic [3:0] a);
    rd = 1; addr = a;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic tbl_load(input logic [3:0] i, input logic [5:0] f);
    twe = 1; taddr = i; tdata = f;
    @(negedge clk);
    twe = 0;
  endtask

  function automatic logic [63:0] cmdw(input logic [7:0] c, input logic [8:0] f);
    return {15'h0, f, 32'h0, c};
  endfunction

  task automatic query(input logic [7:0] c, input logic [8:0] f);
    do_wr(4'h8, cmdw(c, f));
    do_rd(4'h8);
    do_rd(4'h0);
    do_wr(4'h0, 64'h0000_0000_0002_0001);
    for (int k = 0; k < LAT + 2; k++) do_rd(4'h0);
    do_rd(4'hC);
    do_wr(4'h0, 64'h40);
    do_rd(4'h0);
    do_rd(4'hC);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    cur_req = "R1";
    do_rd(4'h0); do_rd(4'h8); do_rd(4'hC);

    cur_req = "R11";
    for (int i = 0; i < DEPTH; i++) tbl_load(4'(i), 6'b000000);
    tbl_load(4'd3, 6'b111111);
    tbl_load(4'd5, 6'b010101);
    tbl_load(4'd9, 6'b101011);
    tbl_load(4'd7, 6'b111110);
    do_wr(4'hC, 64'hFFFF_FFFF_FFFF_FFFF);
    do_rd(4'hC);

    cur_req = "R2";
    do_rd(4'h4); do_rd(4'h2); @(negedge clk); do_rd(4'h0);

    cur_req = "R6";
    do_wr(4'h0, 64'h0000_0000_0002_0001);
    do_rd(4'h0);

    cur_req = "R8";
    query(8'h10, 9'd3);
    cur_req = "R7";
    query(8'h10, 9'd5);
    cur_req = "R8";
    query(8'h10, 9'd9);

    cur_req = "R4";
    do_wr(4'h8, cmdw(8'h10, 9'd3));
    do_wr(4'h8, cmdw(8'h22, 9'd9));
    do_rd(4'h8);
    do_rd(4'h0);
    cur_req = "R6";
    do_wr(4'h0, 64'h0000_0000_0003_0001);
    do_rd(4'h0);
    do_wr(4'h0, 64'h0000_0000_0002_0000);
    do_rd(4'h0);
    cur_req = "R10";
    do_wr(4'h0, 64'h0000_0000_0002_0001);
    do_rd(4'h0);
    do_wr(4'h0, 64'h40);
    do_rd(4'h0);
    for (int k = 0; k < LAT + 1; k++) do_rd(4'h0);
    do_rd(4'hC);

    cur_req = "R9";
    query(8'h22, 9'd5);
    query(8'h10, 9'd7);
    query(8'h10, 9'h103);
    cur_req = "R8";
    query(8'h10, 9'd3);

    cur_req = "R5";
    oob = 1;
    do_rd(4'h0);
    do_wr(4'h8, cmdw(8'h10, 9'd5));
    do_rd(4'h0);
    do_rd(4'h8);
    oob = 0;
    do_rd(4'h0);
    do_wr(4'h8, cmdw(8'h10, 9'd5));
    oob = 1;
    do_rd(4'h0);
    do_wr(4'h0, 64'h0000_0000_0002_0001);
    for (int k = 0; k < LAT + 1; k++) do_rd(4'h0);
    do_rd(4'hC);
    do_wr(4'h0, 64'h40);
    do_rd(4'h0);
    oob = 0;
    do_rd(4'h0);

    cur_req = "R3";
    query(8'h10, 9'd9);

    cur_req = "R1";
    rst = 1;
    @(negedge clk);
    rst = 0;
    do_rd(4'h0); do_rd(4'hC);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule